// File: doc/BRIEF.md
# Memory Peek Engine

This engine serves debug inspection requests against a pair of row-organized memories that take turns as the active and the accumulating buffer. Row addresses arrive as the head of a command FIFO. As long as a command is present, its address is driven onto the debug read ports of both memories. The engine then steps through a fixed run of wait states that covers the memories' read latency. When the data has settled, it writes one response into a response FIFO. The response carries the address with the selected memory's row data appended below it.

A select input names the memory that is currently the accumulating buffer, and that memory's data goes into the response. The command is popped only after its response has been accepted. If the response FIFO is full when the data becomes valid, the engine waits in that wait state until space appears. A host-side agent can therefore queue any number of peeks without losing or duplicating answers.

Top module: `peek_engine`

## Requirements
- R1: While reset is asserted and after it is released, both `cmdRdEn` and `rspWrEn` are 0. The first command presented after release is served normally.
- R2: `mem0RdAddr` and `mem1RdAddr` both equal `cmdData` in every cycle.
- R3: The response word is `{address, data}`. The address is in bits [ADDR_W+DATA_W-1:DATA_W] and the row data in bits [DATA_W-1:0], so the defaults give 22 bits.
- R4: When `memSel` is 1 the response data comes from memory 0. When `memSel` is 0 it comes from memory 1.
- R5: Each command produces exactly one response. Count the first cycle in which the non-empty FIFO head is visible to the idle engine as cycle 0. With the response FIFO not full, `rspWrEn` is high in cycle READ_LAT (1 to 4).
- R6: `rspWrEn` is never high while `rspFull` is high. While full, the engine holds without popping and writes as soon as `rspFull` falls.
- R7: `cmdRdEn` pulses for exactly one cycle per command, only after that command's response has been written. With no back-pressure it is high in cycle 5, and the next queued command is served right after.
- R8: While the command FIFO is empty and no command is in progress, neither enable is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cmdEmpty | input | 1 | Command FIFO empty flag |
| cmdData | input | ADDR_W | Command FIFO head: row address to peek |
| cmdRdEn | output | 1 | Command FIFO pop strobe |
| rspFull | input | 1 | Response FIFO full flag |
| rspData | output | ADDR_W+DATA_W | Response word {address, data} |
| rspWrEn | output | 1 | Response FIFO push strobe |
| memSel | input | 1 | 1: memory 0 is peeked, 0: memory 1 is peeked |
| mem0RdAddr | output | ADDR_W | Debug read address, memory 0 |
| mem0RdData | input | DATA_W | Debug read data, memory 0 |
| mem1RdAddr | output | ADDR_W | Debug read address, memory 1 |
| mem1RdData | input | DATA_W | Debug read data, memory 1 |

## Verification
The bench uses the default widths of 14 address bits and 8 data bits, so it can drive addresses at both ends of the row range. It uses a read latency of 3. The memory models return the contents for the address seen exactly three cycles earlier, so a response taken one cycle early carries the previous address's data and is caught. With a latency of 3 there is one wait state after the response slot and before the pop, which lets the bench tell the response cycle and the pop cycle apart.

// File: rtl/peek_pkg.sv
package peek_pkg;

  typedef enum logic [2:0] {
    ST_RESET = 3'd0,
    ST_IDLE  = 3'd1,
    ST_WAIT0 = 3'd2,
    ST_WAIT1 = 3'd3,
    ST_WAIT2 = 3'd4,
    ST_WAIT3 = 3'd5,
    ST_DONE  = 3'd6
  } peekState_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic pushResp;
    logic popCmd;
  } peekStrobes_t;

endpackage

// File: rtl/peek_ctrl.sv
module peek_ctrl
  import peek_pkg::*;
#(
  parameter int READ_LAT = 3
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         cmdEmpty,
  input  logic         rspFull,
  output peekStrobes_t strobes
);

  // wait state (0..3) in which the read data is first valid
  localparam logic [2:0] SLOT_IDX = 3'(READ_LAT - 1);

  peekState_t state, nextState;
  logic       inWait;
  logic       inSlot;
  logic [2:0] waitIdx;
  logic [1:0] pushCount;

  assign inWait  = (state == ST_WAIT0) || (state == ST_WAIT1) ||
                   (state == ST_WAIT2) || (state == ST_WAIT3);
  assign waitIdx = 3'(state) - 3'(ST_WAIT0);
  assign inSlot  = inWait && (waitIdx == SLOT_IDX);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_RESET;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    unique case (state)
      ST_RESET: nextState = ST_IDLE;
      ST_IDLE:  if (!cmdEmpty) nextState = ST_WAIT0;
      ST_WAIT0: if (!(inSlot && rspFull)) nextState = ST_WAIT1;
      ST_WAIT1: if (!(inSlot && rspFull)) nextState = ST_WAIT2;
      ST_WAIT2: if (!(inSlot && rspFull)) nextState = ST_WAIT3;
      ST_WAIT3: if (!(inSlot && rspFull)) nextState = ST_DONE;
      ST_DONE:  nextState = ST_IDLE;
      default:  nextState = ST_RESET;
    endcase
  end

  always_comb begin
    strobes.pushResp = inSlot && !rspFull;
    strobes.popCmd   = (state == ST_DONE);
  end

  // responses issued since the last pop, kept for the checks below
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 pushCount <= '0;
    else if (strobes.popCmd)   pushCount <= '0;
    else if (strobes.pushResp) pushCount <= pushCount + 2'd1;
  end

  // R5
  push_once_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.pushResp |-> (pushCount == 2'd0));

  // R7
  pop_after_push_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.popCmd |-> (pushCount == 2'd1));

  // R7
  pop_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.popCmd |=> !strobes.popCmd);

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inSlot && rspFull) |=> $stable(state));

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && cmdEmpty) |=> (state == ST_IDLE));

endmodule

// File: rtl/peek_datapath.sv
module peek_datapath
  import peek_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int DATA_W = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  peekStrobes_t               strobes,
  input  logic [ADDR_W-1:0]          cmdData,
  input  logic                       rspFull,
  input  logic                       memSel,
  input  logic [DATA_W-1:0]          mem0RdData,
  input  logic [DATA_W-1:0]          mem1RdData,
  output logic [ADDR_W-1:0]          mem0RdAddr,
  output logic [ADDR_W-1:0]          mem1RdAddr,
  output logic [ADDR_W+DATA_W-1:0]   rspData,
  output logic                       rspWrEn,
  output logic                       cmdRdEn
);

  localparam int NUM_PORTS = 2;

  logic [NUM_PORTS-1:0][ADDR_W-1:0] portAddr;
  logic [DATA_W-1:0]                selData;

  // same head address fans out to every debug read port
  for (genvar g = 0; g < NUM_PORTS; g++) begin : gAddrFan
    assign portAddr[g] = cmdData;
  end

  assign mem0RdAddr = portAddr[0];
  assign mem1RdAddr = portAddr[1];

  assign selData = memSel ? mem0RdData : mem1RdData;
  assign rspData = {cmdData, selData};
  assign rspWrEn = strobes.pushResp;
  assign cmdRdEn = strobes.popCmd;

  // R6
  no_full_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspWrEn |-> !rspFull);

  // R7
  no_joint_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(rspWrEn && cmdRdEn));

endmodule

// File: rtl/peek_engine.sv
module peek_engine
  import peek_pkg::*;
#(
  parameter int ADDR_W   = 14,
  parameter int DATA_W   = 8,
  parameter int READ_LAT = 3
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     cmdEmpty,
  input  logic [ADDR_W-1:0]        cmdData,
  output logic                     cmdRdEn,
  input  logic                     rspFull,
  output logic [ADDR_W+DATA_W-1:0] rspData,
  output logic                     rspWrEn,
  input  logic                     memSel,
  output logic [ADDR_W-1:0]        mem0RdAddr,
  input  logic [DATA_W-1:0]        mem0RdData,
  output logic [ADDR_W-1:0]        mem1RdAddr,
  input  logic [DATA_W-1:0]        mem1RdData
);

  peekStrobes_t strobes;

  peek_ctrl #(.READ_LAT(READ_LAT)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .cmdEmpty (cmdEmpty),
    .rspFull  (rspFull),
    .strobes  (strobes)
  );

  peek_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .cmdData    (cmdData),
    .rspFull    (rspFull),
    .memSel     (memSel),
    .mem0RdData (mem0RdData),
    .mem1RdData (mem1RdData),
    .mem0RdAddr (mem0RdAddr),
    .mem1RdAddr (mem1RdAddr),
    .rspData    (rspData),
    .rspWrEn    (rspWrEn),
    .cmdRdEn    (cmdRdEn)
  );

endmodule

// File: tb/peek_engine_tb_top.sv
module peek_engine_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 14;
  localparam int DATA_W = 8;
  localparam int LAT    = 3;
  localparam int RSP_W  = ADDR_W + DATA_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdEmpty = 1'b1;
  logic [ADDR_W-1:0] cmdData = '0;
  logic cmdRdEn;
  logic rspFull = 1'b0;
  logic [RSP_W-1:0] rspData;
  logic rspWrEn;
  logic memSel = 1'b1;
  logic [ADDR_W-1:0] mem0RdAddr, mem1RdAddr;
  logic [DATA_W-1:0] mem0RdData, mem1RdData;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int headCyc = 0;
  int respCount = 0;
  int popCount = 0;
  bit timingOn = 1'b1;

  logic [ADDR_W-1:0] cmdQ[$];
  logic [RSP_W-1:0]  expQ[$];
  logic [ADDR_W-1:0] pipe0 [LAT];
  logic [ADDR_W-1:0] pipe1 [LAT];

  always #(CLK_PERIOD/2) clk = ~clk;

  peek_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .READ_LAT(LAT)) dut_i (
    .clk(clk), .rstN(rstN), .cmdEmpty(cmdEmpty), .cmdData(cmdData),
    .cmdRdEn(cmdRdEn), .rspFull(rspFull), .rspData(rspData),
    .rspWrEn(rspWrEn), .memSel(memSel), .mem0RdAddr(mem0RdAddr),
    .mem0RdData(mem0RdData), .mem1RdAddr(mem1RdAddr), .mem1RdData(mem1RdData)
  );

  function automatic logic [DATA_W-1:0] memFn(input bit idx, input logic [ADDR_W-1:0] a);
    if (idx) return a[7:0] ^ {a[13:8], 2'b01};
    return (a[7:0] + 8'h5A) ^ a[13:6];
  endfunction

  // memory models: data reflects the address seen LAT cycles earlier
  assign mem0RdData = memFn(1'b0, pipe0[LAT-1]);
  assign mem1RdData = memFn(1'b1, pipe1[LAT-1]);

  always @(posedge clk) begin
    pipe0[0] <= mem0RdAddr;
    pipe1[0] <= mem1RdAddr;
    for (int i = 1; i < LAT; i++) begin
      pipe0[i] <= pipe0[i-1];
      pipe1[i] <= pipe1[i-1];
    end
  end

  // command FIFO model, registered outputs
  always @(posedge clk) begin
    bit wasEmpty;
    bit popped;
    wasEmpty = cmdEmpty;
    popped = 1'b0;
    cyc <= cyc + 1;
    if (cmdRdEn && cmdQ.size() > 0) begin
      void'(cmdQ.pop_front());
      popped = 1'b1;
    end
    cmdEmpty <= (cmdQ.size() == 0);
    cmdData  <= (cmdQ.size() > 0) ? cmdQ[0] : '0;
    if (cmdQ.size() > 0 && (wasEmpty || popped)) headCyc <= cyc + 1;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN) begin
      check(mem0RdAddr == cmdData && mem1RdAddr == cmdData, "R2 read address",
            {18'd0, mem0RdAddr}, {18'd0, cmdData});
      if (rspWrEn) begin
        check(!rspFull, "R6 write while full", 32'(rspFull), 32'd0);
        check(respCount == popCount, "R5 one response per command",
              32'(respCount), 32'(popCount));
        if (expQ.size() == 0) begin
          check(1'b0, "R5 unexpected response", {10'd0, rspData}, 32'd0);
        end else begin
          logic [RSP_W-1:0] e;
          e = expQ.pop_front();
          // R3 R4: {address, data from selected memory}
          check(rspData == e, "R3/R4 response word", {10'd0, rspData}, {10'd0, e});
        end
        if (timingOn)
          check(cyc == headCyc + LAT, "R5 response cycle", 32'(cyc), 32'(headCyc + LAT));
        respCount++;
      end
      if (cmdRdEn) begin
        check(respCount == popCount + 1, "R7 pop after response",
              32'(respCount), 32'(popCount + 1));
        if (timingOn)
          check(cyc == headCyc + 5, "R7 pop cycle", 32'(cyc), 32'(headCyc + 5));
        popCount++;
      end
    end
  end

  task automatic sendCmd(input logic [ADDR_W-1:0] a);
    @(negedge clk);
    cmdQ.push_back(a);
    expQ.push_back({a, memSel ? memFn(1'b0, a) : memFn(1'b1, a)});
  endtask

  task automatic drain();
    for (int i = 0; i < 400 && (cmdQ.size() > 0 || !cmdEmpty); i++) @(negedge clk);
    repeat (3) @(negedge clk);
    check(expQ.size() == 0, "R5 all responses delivered", 32'(expQ.size()), 32'd0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    // R1: reset state
    repeat (3) @(negedge clk);
    check(!cmdRdEn && !rspWrEn, "R1 enables low in reset", {30'd0, cmdRdEn, rspWrEn}, 32'd0);
    rstN = 1'b1;
    // R8: empty FIFO keeps engine quiet
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      check(!cmdRdEn && !rspWrEn, "R8 quiet while empty", {30'd0, cmdRdEn, rspWrEn}, 32'd0);
    end
    // R1/R4: first command served, memory 0 selected
    memSel = 1'b1;
    sendCmd(14'h0123);
    drain();
    // back-to-back burst, memory 0 (R7)
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      cmdQ.push_back(14'(i * 1311 + 7));
      expQ.push_back({14'(i * 1311 + 7), memFn(1'b0, 14'(i * 1311 + 7))});
    end
    drain();
    // R4: memory 1 selected, boundary rows
    memSel = 1'b0;
    sendCmd(14'h0000);
    sendCmd(14'h3FFF);
    sendCmd(14'h2AAA);
    drain();
    // R6: back-pressure holds response and pop
    timingOn = 1'b0;
    rspFull = 1'b1;
    sendCmd(14'h1555);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      check(!cmdRdEn && !rspWrEn, "R6 stall while full", {30'd0, cmdRdEn, rspWrEn}, 32'd0);
    end
    check(expQ.size() == 1, "R6 response pending", 32'(expQ.size()), 32'd1);
    rspFull = 1'b0;
    @(negedge clk);
    check(respCount == popCount + 1, "R6 write once space frees",
          32'(respCount), 32'(popCount + 1));
    drain();
    // R6: toggling full during a burst
    memSel = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      cmdQ.push_back(14'(16'h3F00 + i * 3));
      expQ.push_back({14'(16'h3F00 + i * 3), memFn(1'b0, 14'(16'h3F00 + i * 3))});
    end
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      rspFull = (i % 5) < 2;
    end
    rspFull = 1'b0;
    drain();
    timingOn = 1'b1;
    // R7: timing restored after stall, then quiet
    sendCmd(14'h0F0F);
    drain();
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(!cmdRdEn && !rspWrEn, "R8 quiet after traffic", {30'd0, cmdRdEn, rspWrEn}, 32'd0);
    end
    check(respCount == popCount, "R7 pops match responses", 32'(popCount), 32'(respCount));
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule